// File: doc/BRIEF.md
# Serial DMA Request Decoder

This block sits on the host end of a low-pin-count bus and listens to two active-low serial request lines, one per peripheral, both sampled on the bus clock. A peripheral opens a message by pulling its line low for one clock. It then sends a 3-bit channel number, most significant bit first, and one action bit. The action bit either posts a request for that channel or withdraws one posted earlier. Each line has its own framer, and the decoded messages update a sticky pending flag per channel.

A transfer engine reads the pending flags and pulses a per-channel clear when a transfer finishes. Channels below 4 are reported as 8-bit requests, channels above 4 as 16-bit requests, and channel 4 as a bus-master request. A line that goes low during the mandatory high clock after the action bit raises a one-clock protocol error flag for that line. That low clock does not open a new message.

Top module: `dreq_decoder`

## Requirements
- R1: After reset, both framers are idle, every pending flag is 0 and both protocol error flags are 0.
- R2: A message is one low start clock, three channel bits sent MSB first (line high = 1), and one action bit. An action bit of 1 sets the pending flag of that channel, and the flag is visible from the clock after the action bit.
- R3: An action bit of 0 clears the pending flag of the named channel. Withdrawing a channel that is not pending changes no flag.
- R4: Pending flags are sticky. A start bit is accepted in the clock right after the one mandatory high clock, so messages can arrive back to back, and every channel they set stays pending until it is withdrawn or cleared.
- R5: The two lines are decoded independently. Messages arriving at the same time on both lines for different channels both take effect.
- R6: When the two lines post a set and a withdraw for the same channel in the same clock, the withdraw wins and the flag ends at 0.
- R7: A one-clock pulse on bit c of `clearIn` clears pending flag c. This clear wins over a set for channel c that lands in the same clock.
- R8: A low level in the mandatory high clock after the action bit pulses bit l of `protoErr` for one clock, one clock later. That low clock is not taken as a start bit.
- R9: `pendNarrow` shows pending channels 0 to 3, `pendWide` shows pending channels 5 to 7, and `masterReq` equals the pending flag of channel 4. All other bits of `pendNarrow` and `pendWide` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; both lines are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqLineN | input | 2 | Active-low serial request lines, one per peripheral |
| clearIn | input | 8 | One-clock per-channel clear from the transfer engine |
| pending | output | 8 | Sticky pending flag per channel |
| pendNarrow | output | 8 | Pending flags of the 8-bit channels (0 to 3) |
| pendWide | output | 8 | Pending flags of the 16-bit channels (5 to 7) |
| masterReq | output | 1 | Bus-master request (pending flag of channel 4) |
| protoErr | output | 2 | One-clock protocol error pulse per line |

## Verification
The bench uses the default parameters: two lines, a 3-bit channel code, the master channel at 4 and four narrow channels. With these values all eight channel numbers can be named from either line. This also allows a set and a withdraw of the same channel to be placed in the same clock, and the narrow, master and wide groups can each be seen filling and emptying. The protocol error path is driven with a low gap clock followed by a run of highs. With that stimulus, a framer that wrongly took the gap clock as a start bit would decode a visible request for channel 7.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  // width of the serial channel code; channel count is derived from it
  localparam int CHAN_W = 3;
  localparam int NUM_CHAN = 1 << CHAN_W;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_DATA,
    FR_ACT,
    FR_GAP
  } frState_e;

  // strobes from one framer to the pending register
  typedef struct packed {
    logic              hit;   // action bit on the line this clock
    logic              act;   // 1 = post, 0 = withdraw
    logic [CHAN_W-1:0] chan;  // decoded channel number
    logic              err;   // low level during mandatory gap clock
  } frStrobe_t;

endpackage

// File: rtl/dreq_framer.sv
module dreq_framer
  import dreq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineN,
  output frStrobe_t strobe
);

  localparam int CNT_W = (CHAN_W > 1) ? $clog2(CHAN_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAN_W - 1);

  frState_e          stateQ;
  logic [CNT_W-1:0]  bitCntQ;
  logic [CHAN_W-1:0] shiftQ;
  logic [CHAN_W-1:0] shiftNext;

  assign shiftNext = (shiftQ << 1) | CHAN_W'(lineN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= FR_IDLE;
      bitCntQ <= '0;
      shiftQ  <= '0;
    end else begin
      case (stateQ)
        FR_IDLE: begin
          if (!lineN) begin
            stateQ  <= FR_DATA;
            bitCntQ <= '0;
          end
        end
        FR_DATA: begin
          shiftQ <= shiftNext;
          if (bitCntQ == LAST_BIT) stateQ <= FR_ACT;
          else bitCntQ <= bitCntQ + 1'b1;
        end
        FR_ACT:  stateQ <= FR_GAP;
        default: stateQ <= FR_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.hit  = (stateQ == FR_ACT);
    strobe.act  = lineN;
    strobe.chan = shiftQ;
    strobe.err  = (stateQ == FR_GAP) && !lineN;
  end

  // R2
  frame_strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hit |=> !strobe.hit);

  // R8
  gap_err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.err |=> (stateQ == FR_IDLE));

endmodule

// File: rtl/dreq_pendreg.sv
module dreq_pendreg
  import dreq_pkg::*;
#(
  parameter int NUM_LINES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  frStrobe_t            strobeIn [NUM_LINES],
  input  logic [NUM_CHAN-1:0]  clearIn,
  output logic [NUM_CHAN-1:0]  pendQ,
  output logic [NUM_LINES-1:0] errQ
);

  logic [NUM_CHAN-1:0]  setMask;
  logic [NUM_CHAN-1:0]  wdMask;
  logic [NUM_CHAN-1:0]  pendNext;
  logic [NUM_LINES-1:0] errNext;

  always_comb begin
    setMask = '0;
    wdMask  = '0;
    errNext = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      errNext[l] = strobeIn[l].err;
      if (strobeIn[l].hit) begin
        if (strobeIn[l].act) setMask[strobeIn[l].chan] = 1'b1;
        else                 wdMask[strobeIn[l].chan]  = 1'b1;
      end
    end
    // withdraw and clear both beat a set
    pendNext = (pendQ | setMask) & ~wdMask & ~clearIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      errQ  <= '0;
    end else begin
      pendQ <= pendNext;
      errQ  <= errNext;
    end
  end

  // R2
  set_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(setMask & ~wdMask & ~clearIn)) |=>
      ((pendQ & $past(setMask & ~wdMask & ~clearIn)) == $past(setMask & ~wdMask & ~clearIn)));

  // R6
  withdraw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|wdMask) |=> ((pendQ & $past(wdMask)) == '0));

  // R7
  clr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|clearIn) |=> ((pendQ & $past(clearIn)) == '0));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((pendQ ^ $past(pendQ)) & ~$past(setMask | wdMask | clearIn)) == '0));

endmodule

// File: rtl/dreq_decoder.sv
module dreq_decoder
  import dreq_pkg::*;
#(
  parameter int NUM_LINES    = 2,
  parameter int MASTER_CHAN  = 4,
  parameter int NARROW_COUNT = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqLineN,
  input  logic [NUM_CHAN-1:0]  clearIn,
  output logic [NUM_CHAN-1:0]  pending,
  output logic [NUM_CHAN-1:0]  pendNarrow,
  output logic [NUM_CHAN-1:0]  pendWide,
  output logic                 masterReq,
  output logic [NUM_LINES-1:0] protoErr
);

  frStrobe_t           strobes [NUM_LINES];
  logic [NUM_CHAN-1:0] narrowMask;
  logic [NUM_CHAN-1:0] wideMask;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    dreq_framer u_framer (
      .clk    (clk),
      .rstN   (rstN),
      .lineN  (reqLineN[l]),
      .strobe (strobes[l])
    );
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_class
    assign narrowMask[c] = (c < NARROW_COUNT);
    assign wideMask[c]   = (c > MASTER_CHAN);
  end

  dreq_pendreg #(
    .NUM_LINES (NUM_LINES)
  ) u_pend (
    .clk      (clk),
    .rstN     (rstN),
    .strobeIn (strobes),
    .clearIn  (clearIn),
    .pendQ    (pending),
    .errQ     (protoErr)
  );

  assign pendNarrow = pending & narrowMask;
  assign pendWide   = pending & wideMask;
  assign masterReq  = pending[MASTER_CHAN];

endmodule

// File: tb/dreq_decoder_tb.sv
module dreq_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] reqLineN = 2'b11;
  logic [7:0] clearIn = '0;
  logic [7:0] pending, pendNarrow, pendWide;
  logic       masterReq;
  logic [1:0] protoErr;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dreq_decoder u_dut (
    .clk(clk), .rstN(rstN), .reqLineN(reqLineN), .clearIn(clearIn),
    .pending(pending), .pendNarrow(pendNarrow), .pendWide(pendWide),
    .masterReq(masterReq), .protoErr(protoErr)
  );

  // vector: req(4) v0 ch0(3) a0 v1 ch1(3) a1
  localparam logic [13:0] VEC [NVEC] = '{
    {4'd2, 1'b1, 3'd2, 1'b1, 1'b0, 3'd0, 1'b0},  // R2 line0 posts ch2
    {4'd4, 1'b1, 3'd3, 1'b1, 1'b0, 3'd0, 1'b0},  // R4 back to back ch3
    {4'd5, 1'b1, 3'd0, 1'b1, 1'b1, 3'd6, 1'b1},  // R5 both lines at once
    {4'd9, 1'b1, 3'd4, 1'b1, 1'b0, 3'd0, 1'b0},  // R9 master channel
    {4'd9, 1'b1, 3'd7, 1'b1, 1'b1, 3'd5, 1'b1},  // R9 wide channels
    {4'd3, 1'b1, 3'd3, 1'b0, 1'b0, 3'd0, 1'b0},  // R3 withdraw ch3
    {4'd3, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b0},  // R3 withdraw idle ch1
    {4'd6, 1'b1, 3'd6, 1'b1, 1'b1, 3'd6, 1'b0},  // R6 set vs withdraw
    {4'd6, 1'b1, 3'd2, 1'b0, 1'b1, 3'd2, 1'b1},  // R6 withdraw vs set
    {4'd4, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b1}   // R4 ch1 joins
  };

  task automatic check(input int req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input int req);
    logic [7:0] expNarrow, expWide;
    expNarrow = model & 8'h0F;
    expWide   = model & 8'hE0;
    check(req, "pending", pending, model);
    check(9, "pendNarrow", pendNarrow, expNarrow);
    check(9, "pendWide", pendWide, expWide);
    check(9, "masterReq", {7'd0, masterReq}, {7'd0, model[4]});
  endtask

  // model of one decoding clock: withdraw and clear beat set
  task automatic modelApply(input logic v0, input logic [2:0] c0, input logic a0,
                            input logic v1, input logic [2:0] c1, input logic a1,
                            input logic [7:0] clr);
    logic [7:0] s, w;
    s = '0; w = '0;
    if (v0) begin if (a0) s[c0] = 1'b1; else w[c0] = 1'b1; end
    if (v1) begin if (a1) s[c1] = 1'b1; else w[c1] = 1'b1; end
    model = (model | s) & ~w & ~clr;
  endtask

  // six clocks: start, three code bits MSB first, action bit, gap
  task automatic sendPair(input logic v0, input logic [2:0] c0, input logic a0,
                          input logic v1, input logic [2:0] c1, input logic a1,
                          input logic [7:0] clrAtAct, input logic [1:0] gapLow);
    @(negedge clk) reqLineN = {~v1, ~v0};
    for (int b = 2; b >= 0; b--) begin
      @(negedge clk) reqLineN = {v1 ? c1[b] : 1'b1, v0 ? c0[b] : 1'b1};
    end
    @(negedge clk);
    reqLineN = {v1 ? a1 : 1'b1, v0 ? a0 : 1'b1};
    clearIn  = clrAtAct;
    @(negedge clk);
    reqLineN = ~gapLow;
    clearIn  = '0;
    modelApply(v0, c0, a0, v1, c1, a1, clrAtAct);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, "pending in reset", pending, 8'h00);
    check(1, "protoErr in reset", {6'd0, protoErr}, 8'h00);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      sendPair(VEC[i][9], VEC[i][8:6], VEC[i][5],
               VEC[i][4], VEC[i][3:1], VEC[i][0], 8'h00, 2'b00);
      checkAll(int'(VEC[i][13:10]));
    end

    // R7 clear while idle
    @(negedge clk) clearIn = 8'h01;
    @(negedge clk) clearIn = 8'h00;
    model[0] = 1'b0;
    checkAll(7);

    // R7 clear beats a set landing in the same clock
    sendPair(1'b1, 3'd3, 1'b1, 1'b0, 3'd0, 1'b0, 8'h08, 2'b00);
    checkAll(7);

    // R8 low in gap: error pulse, then ones must decode nothing
    sendPair(1'b0, 3'd0, 1'b0, 1'b1, 3'd0, 1'b1, 8'h00, 2'b10);
    @(negedge clk) reqLineN = 2'b11;
    check(8, "protoErr pulse", {6'd0, protoErr}, 8'h02);
    @(negedge clk);
    check(8, "protoErr drops", {6'd0, protoErr}, 8'h00);
    repeat (6) @(negedge clk);
    checkAll(8);

    // R1 reset mid-run clears flags
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    model = '0;
    checkAll(1);
    @(negedge clk) rstN = 1'b1;

    // R2 after reset a fresh message still decodes
    sendPair(1'b0, 3'd0, 1'b0, 1'b1, 3'd7, 1'b1, 8'h00, 2'b00);
    checkAll(2);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule